// File: doc/BRIEF.md
# Host-Port FIFO Reset Sequencer

This block orders the reset of the host-port read and write FIFOs so that it does not interfere with a host access that is already in progress. Two kinds of reset reach it. The CPU can request a software reset by writing 1 to a control bit. A chip-level hardware reset can also arrive through an external input. The block watches an internal host strobe, which is low while a host cycle is running, and a flag that shows FIFO DMA transfers are still outstanding. From these it drives the host wait line, where high holds the host off.

A software reset waits for outstanding FIFO DMAs to finish. If a host cycle is running, the block then lowers the wait line for a while so that the host can finish its cycle. When the strobe rises, the block holds the host off, clears both FIFO pointers with a one-cycle pulse, and reports completion through the readback of the control bit. A software reset touches only the FIFOs.

A hardware reset takes priority over any software sequence. It does not wait for DMAs. It also restores the host-port registers to their defaults and clears the host/CPU interrupts. The host stays held off until the external reset input is released.

Top module: `hp_fifo_rst_seq`

## Requirements
- R1: After `rst_n` is released, with no requests present, `host_wait`, `rst_busy`, `fifo_clr`, `reg_dflt`, `irq_clr` and `cpu_rd_bit` are all 0.
- R2: A CPU write of 1 (`cpu_wr_en`=1, `cpu_wr_bit`=1) while the sequencer is idle and `host_strobe_n` is 1 raises `host_wait` in the next cycle. `host_wait` then stays 1 until the sequence ends.
- R3: If `host_strobe_n` is 0 when a software reset starts, `host_wait` is 1 while `dma_busy` is 1. It is then 0 from the cycle after `dma_busy` is seen low until the cycle after `host_strobe_n` is seen high, and 1 again from that cycle on.
- R4: `fifo_clr` is a single-cycle pulse. In a software reset it occurs only after `dma_busy` has been sampled 0 while the host is held off.
- R5: `cpu_rd_bit` reads 0 from the start of a software reset until the cycle after the `fifo_clr` pulse, when it becomes 1. An idle CPU write of 0 returns it to 0.
- R6: CPU writes of any value while a sequence is in progress are ignored. A write of 0 does not abort a running software reset.
- R7: A software reset never asserts `reg_dflt` or `irq_clr`.
- R8: A hardware reset is seen `SYNC_STAGES` cycles after `hw_rst_i` rises. It releases an active host cycle without waiting for DMAs. It then pulses `fifo_clr`, `reg_dflt` and `irq_clr` together in a single cycle.
- R9: A hardware reset that arrives during a software reset takes over the sequence.
- R10: `rst_busy` is 1 from the cycle after a reset starts through the `fifo_clr` cycle, and 0 afterwards.
- R11: After the clear, `host_wait` stays 1 one cycle for a software reset. For a hardware reset it stays 1 until the synchronized `hw_rst_i` is low. Only then does `host_wait` return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer's own flops |
| hw_rst_i | input | 1 | Chip-level hardware reset request, asynchronous, active high |
| host_strobe_n | input | 1 | Internal host strobe, 0 while a host cycle is active |
| dma_busy | input | 1 | FIFO DMA transfers still outstanding |
| cpu_wr_en | input | 1 | CPU write strobe for the software reset bit |
| cpu_wr_bit | input | 1 | Value the CPU writes to the software reset bit |
| cpu_rd_bit | output | 1 | Readback of the software reset bit |
| host_wait | output | 1 | Host hold-off line, 1 holds the host |
| fifo_clr | output | 1 | One-cycle pointer clear to both FIFOs |
| reg_dflt | output | 1 | One-cycle restore of host-port registers to default |
| irq_clr | output | 1 | One-cycle clear of host-to-CPU and CPU-to-host interrupts |
| rst_busy | output | 1 | Reset in progress, up to and including the clear cycle |

## Verification
The properties assume that every input is synchronous to `clk` and free of unknown values after reset, apart from `hw_rst_i`, which goes through the synchronizer. They also assume that `dma_busy` and `host_strobe_n` may change on any cycle. The stimulus drives all inputs on the falling edge. It toggles the strobe and the DMA flag at random, issues CPU writes of either value, including writes in the middle of a sequence, and holds `hw_rst_i` high for several cycles at a time. The hardware request therefore always passes the synchronizer as a clean level.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_DMA = 3'd1,
        ST_RELEASE  = 3'd2,
        ST_HOLD     = 3'd3,
        ST_CLEAR    = 3'd4,
        ST_DONE     = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       hw_mode;
    } seq_regs_t;

endpackage

// File: rtl/hrs_sync.sv
module hrs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stages_d, stages_q;
    logic [STAGES:0]   chain;

    always_comb begin
        chain    = {stages_q, din};
        stages_d = chain[STAGES-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stages_q <= '0;
        else        stages_q <= stages_d;
    end

    assign dout = stages_q[STAGES-1];
endmodule

// File: rtl/hrs_swbit.sv
module hrs_swbit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic seq_idle,
    input  logic hw_start,
    input  logic sw_done,
    output logic sw_start,
    output logic rd_bit
);
    logic done_d, done_q;

    always_comb begin
        sw_start = wr_en && wr_bit && seq_idle;
        done_d   = done_q;
        if (hw_start)                done_d = 1'b0;
        else if (sw_done)            done_d = 1'b1;
        else if (wr_en && seq_idle)  done_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= done_d;
    end

    assign rd_bit = done_q;
endmodule

// File: rtl/hrs_seq_fsm.sv
module hrs_seq_fsm
    import hrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_seen,
    input  logic       host_strobe_n,
    input  logic       dma_busy,
    input  logic       sw_start,
    output logic       hw_start,
    output logic       sw_done,
    output logic       seq_idle,
    output seq_state_e state,
    output logic       hw_mode
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        hw_start = hw_seen && !r_q.hw_mode;
        sw_done  = (r_q.state == ST_CLEAR) && !r_q.hw_mode;
        if (hw_start) begin
            r_d.hw_mode = 1'b1;
            r_d.state   = host_strobe_n ? ST_HOLD : ST_RELEASE;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (sw_start)
                        r_d.state = host_strobe_n ? ST_HOLD : ST_WAIT_DMA;
                end
                ST_WAIT_DMA: begin
                    if (!dma_busy) r_d.state = ST_RELEASE;
                end
                ST_RELEASE: begin
                    if (host_strobe_n) r_d.state = ST_HOLD;
                end
                ST_HOLD: begin
                    if (r_q.hw_mode || !dma_busy) r_d.state = ST_CLEAR;
                end
                ST_CLEAR: begin
                    r_d.state = ST_DONE;
                end
                ST_DONE: begin
                    if (!(r_q.hw_mode && hw_seen)) begin
                        r_d.state   = ST_IDLE;
                        r_d.hw_mode = 1'b0;
                    end
                end
                default: begin
                    r_d.state   = ST_IDLE;
                    r_d.hw_mode = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.hw_mode <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign seq_idle = (r_q.state == ST_IDLE);
    assign state    = r_q.state;
    assign hw_mode  = r_q.hw_mode;
endmodule

// File: rtl/hrs_outdec.sv
module hrs_outdec
    import hrs_pkg::*;
(
    input  seq_state_e state,
    input  logic       hw_mode,
    output logic       host_wait,
    output logic       rst_busy,
    output logic       fifo_clr,
    output logic       reg_dflt,
    output logic       irq_clr
);
    always_comb begin
        host_wait = 1'b0;
        rst_busy  = 1'b0;
        fifo_clr  = 1'b0;
        unique case (state)
            ST_WAIT_DMA: begin host_wait = 1'b1; rst_busy = 1'b1; end
            ST_RELEASE:  begin rst_busy = 1'b1; end
            ST_HOLD:     begin host_wait = 1'b1; rst_busy = 1'b1; end
            ST_CLEAR:    begin host_wait = 1'b1; rst_busy = 1'b1; fifo_clr = 1'b1; end
            ST_DONE:     begin host_wait = 1'b1; end
            default:     begin end
        endcase
        reg_dflt = fifo_clr && hw_mode;
        irq_clr  = fifo_clr && hw_mode;
    end
endmodule

// File: rtl/hp_fifo_rst_seq.sv
module hp_fifo_rst_seq
    import hrs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_rst_i,
    input  logic host_strobe_n,
    input  logic dma_busy,
    input  logic cpu_wr_en,
    input  logic cpu_wr_bit,
    output logic cpu_rd_bit,
    output logic host_wait,
    output logic fifo_clr,
    output logic reg_dflt,
    output logic irq_clr,
    output logic rst_busy
);
    logic       hw_sync;
    logic       sw_start, hw_start, sw_done, seq_idle, hw_mode;
    seq_state_e state;

    hrs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din (hw_rst_i),
        .dout (hw_sync)
    );

    hrs_swbit u_swbit (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr_en),
        .wr_bit   (cpu_wr_bit),
        .seq_idle (seq_idle),
        .hw_start (hw_start),
        .sw_done  (sw_done),
        .sw_start (sw_start),
        .rd_bit   (cpu_rd_bit)
    );

    hrs_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hw_seen       (hw_sync),
        .host_strobe_n (host_strobe_n),
        .dma_busy      (dma_busy),
        .sw_start      (sw_start),
        .hw_start      (hw_start),
        .sw_done       (sw_done),
        .seq_idle      (seq_idle),
        .state         (state),
        .hw_mode       (hw_mode)
    );

    hrs_outdec u_dec (
        .state     (state),
        .hw_mode   (hw_mode),
        .host_wait (host_wait),
        .rst_busy  (rst_busy),
        .fifo_clr  (fifo_clr),
        .reg_dflt  (reg_dflt),
        .irq_clr   (irq_clr)
    );
endmodule

// File: rtl/hrs_checker.sv
module hrs_checker (
    input logic clk,
    input logic rst_n,
    input logic hw_seen,
    input logic host_strobe_n,
    input logic dma_busy,
    input logic cpu_rd_bit,
    input logic host_wait,
    input logic fifo_clr,
    input logic reg_dflt,
    input logic irq_clr,
    input logic rst_busy
);
    // R3: once released, the host stays released while its strobe is low
    a_r3_release_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wait && rst_busy && !host_strobe_n) |=> !host_wait);

    // R4: the clear is a single-cycle pulse
    a_r4_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> !fifo_clr);

    // R4: a software clear follows a cycle with no DMA outstanding
    a_r4_clr_after_dma: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_clr && !reg_dflt) |-> !$past(dma_busy));

    // R5: the readback becomes 1 only right after a software clear
    a_r5_rd_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rd_bit) |-> ($past(fifo_clr) && !$past(reg_dflt)));

    // R8: interrupt clear only comes together with a FIFO clear
    a_r8_irq_with_clr: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |-> (fifo_clr && reg_dflt));

    // R10: busy cannot drop before the clear cycle
    a_r10_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_busy && !fifo_clr) |=> rst_busy);

    // R11: host stays held after the clear while hardware reset is present
    a_r11_hold_hw: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wait && !rst_busy && hw_seen && host_strobe_n) |=> host_wait);
endmodule

bind hp_fifo_rst_seq hrs_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hw_seen       (hw_sync),
    .host_strobe_n (host_strobe_n),
    .dma_busy      (dma_busy),
    .cpu_rd_bit    (cpu_rd_bit),
    .host_wait     (host_wait),
    .fifo_clr      (fifo_clr),
    .reg_dflt      (reg_dflt),
    .irq_clr       (irq_clr),
    .rst_busy      (rst_busy)
);

// File: tb/tb_hp_fifo_rst_seq.sv
module tb_hp_fifo_rst_seq;
    localparam int SYNC = 2;
    localparam int M_IDLE = 0, M_WAIT = 1, M_REL = 2, M_HOLD = 3, M_CLR = 4, M_DONE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_rst_i = 1'b0, host_strobe_n = 1'b1, dma_busy = 1'b0;
    logic cpu_wr_en = 1'b0, cpu_wr_bit = 1'b0;
    logic cpu_rd_bit, host_wait, fifo_clr, reg_dflt, irq_clr, rst_busy;

    int checks = 0;
    int errors = 0;

    int m_state = M_IDLE;
    bit m_hw = 1'b0;
    bit m_flag = 1'b0;
    bit [SYNC-1:0] m_sync = '0;

    always #2 clk = ~clk;

    hp_fifo_rst_seq #(.SYNC_STAGES(SYNC)) dut (
        .clk (clk), .rst_n (rst_n), .hw_rst_i (hw_rst_i),
        .host_strobe_n (host_strobe_n), .dma_busy (dma_busy),
        .cpu_wr_en (cpu_wr_en), .cpu_wr_bit (cpu_wr_bit),
        .cpu_rd_bit (cpu_rd_bit), .host_wait (host_wait),
        .fifo_clr (fifo_clr), .reg_dflt (reg_dflt),
        .irq_clr (irq_clr), .rst_busy (rst_busy)
    );

    // Reference model built from the requirements
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = M_IDLE; m_hw = 1'b0; m_flag = 1'b0; m_sync = '0;
        end else begin
            bit hw_s, hw_start, idle;
            int ns;
            bit nhw;
            hw_s     = m_sync[SYNC-1];
            idle     = (m_state == M_IDLE);
            hw_start = hw_s && !m_hw;
            ns = m_state; nhw = m_hw;
            if (hw_start) m_flag = 1'b0;
            else if (m_state == M_CLR && !m_hw) m_flag = 1'b1;
            else if (cpu_wr_en && idle) m_flag = 1'b0;
            if (hw_start) begin
                nhw = 1'b1; ns = host_strobe_n ? M_HOLD : M_REL;
            end else begin
                case (m_state)
                    M_IDLE: if (cpu_wr_en && cpu_wr_bit) ns = host_strobe_n ? M_HOLD : M_WAIT;
                    M_WAIT: if (!dma_busy) ns = M_REL;
                    M_REL:  if (host_strobe_n) ns = M_HOLD;
                    M_HOLD: if (m_hw || !dma_busy) ns = M_CLR;
                    M_CLR:  ns = M_DONE;
                    M_DONE: if (!(m_hw && hw_s)) begin ns = M_IDLE; nhw = 1'b0; end
                    default: ns = M_IDLE;
                endcase
            end
            m_state = ns; m_hw = nhw;
            m_sync = {m_sync[SYNC-2:0], hw_rst_i};
        end
    end

    function automatic bit exp_wait(int s);
        return (s == M_WAIT) || (s == M_HOLD) || (s == M_CLR) || (s == M_DONE);
    endfunction
    function automatic bit exp_busy(int s);
        return (s == M_WAIT) || (s == M_REL) || (s == M_HOLD) || (s == M_CLR);
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R3 host_wait", host_wait, exp_wait(m_state));
        check("R10 rst_busy", rst_busy, exp_busy(m_state));
        check("R4 fifo_clr", fifo_clr, m_state == M_CLR);
        check("R7/R8 reg_dflt", reg_dflt, (m_state == M_CLR) && m_hw);
        check("R8 irq_clr", irq_clr, (m_state == M_CLR) && m_hw);
        check("R5 cpu_rd_bit", cpu_rd_bit, m_flag);
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hw_cnt;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R1 host_wait", host_wait, 1'b0);
        check("R1 rst_busy", rst_busy, 1'b0);
        check("R1 fifo_clr", fifo_clr, 1'b0);
        check("R1 cpu_rd_bit", cpu_rd_bit, 1'b0);

        // R2 / R4 / R6 / R7 / R5: software reset with host idle
        host_strobe_n = 1'b1; dma_busy = 1'b1;
        cpu_wr_en = 1'b1; cpu_wr_bit = 1'b1;
        step();
        cpu_wr_en = 1'b0;
        check("R2 wait at once", host_wait, 1'b1);
        check("R10 busy at start", rst_busy, 1'b1);
        step(); step();
        check("R4 no clear while DMA busy", fifo_clr, 1'b0);
        cpu_wr_en = 1'b1; cpu_wr_bit = 1'b0;
        step();
        cpu_wr_en = 1'b0;
        check("R6 write 0 does not abort", rst_busy, 1'b1);
        check("R5 reads 0 during reset", cpu_rd_bit, 1'b0);
        dma_busy = 1'b0;
        step();
        check("R4 clear after DMA", fifo_clr, 1'b1);
        check("R7 no register restore", reg_dflt, 1'b0);
        step();
        check("R5 reads 1 after clear", cpu_rd_bit, 1'b1);
        check("R11 held one cycle", host_wait, 1'b1);
        step();
        check("R11 released after sw", host_wait, 1'b0);
        cpu_wr_en = 1'b1; cpu_wr_bit = 1'b0;
        step();
        cpu_wr_en = 1'b0;
        check("R5 write 0 clears readback", cpu_rd_bit, 1'b0);

        // R3: software reset with host active
        host_strobe_n = 1'b0; dma_busy = 1'b1;
        cpu_wr_en = 1'b1; cpu_wr_bit = 1'b1;
        step();
        cpu_wr_en = 1'b0;
        check("R3 hold while DMA", host_wait, 1'b1);
        dma_busy = 1'b0;
        step();
        check("R3 release host", host_wait, 1'b0);
        check("R3 still busy", rst_busy, 1'b1);
        step();
        check("R3 release kept", host_wait, 1'b0);
        host_strobe_n = 1'b1;
        step();
        check("R3 hold after strobe rise", host_wait, 1'b1);
        repeat (4) step();

        // R9 / R8 / R11: hardware reset takes over a software reset
        host_strobe_n = 1'b0; dma_busy = 1'b1;
        cpu_wr_en = 1'b1; cpu_wr_bit = 1'b1;
        step();
        cpu_wr_en = 1'b0;
        hw_rst_i = 1'b1;
        for (int i = 0; i < SYNC; i++) step();
        check("R9 still waiting before sync", host_wait, 1'b1);
        step();
        check("R9 hw releases host without DMA wait", host_wait, 1'b0);
        host_strobe_n = 1'b1;
        step();
        check("R8 hold after strobe", host_wait, 1'b1);
        step();
        check("R8 fifo clear", fifo_clr, 1'b1);
        check("R8 register restore", reg_dflt, 1'b1);
        check("R8 interrupt clear", irq_clr, 1'b1);
        repeat (5) step();
        check("R11 held during hw reset", host_wait, 1'b1);
        hw_rst_i = 1'b0;
        for (int i = 0; i < SYNC; i++) step();
        check("R11 held until sync drops", host_wait, 1'b1);
        step();
        check("R11 released after hw", host_wait, 1'b0);
        dma_busy = 1'b0;

        // Random phase
        hw_cnt = 0;
        for (int i = 0; i < 6000; i++) begin
            step();
            if ($urandom % 4 == 0) host_strobe_n = ~host_strobe_n;
            dma_busy   = ($urandom % 3 == 0);
            cpu_wr_en  = ($urandom % 10 == 0);
            cpu_wr_bit = $urandom % 2;
            if (hw_cnt > 0) begin
                hw_cnt--; hw_rst_i = 1'b1;
            end else if ($urandom % 200 == 0) begin
                hw_cnt = 2 + ($urandom % 6); hw_rst_i = 1'b1;
            end else begin
                hw_rst_i = 1'b0;
            end
        end
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule